// File: doc/BRIEF.md
# I2C Pin Expander with Change Interrupt

This block gives a host eight general-purpose pins, reached as a slave on a two-wire I2C bus. Behind the bus sit four byte-wide registers. One shows the levels on the pins. One holds the levels that output pins drive. One inverts chosen bits of the pin levels before they are read. One sets each pin's direction. A command byte that the host writes after the slave address picks the register that the following data bytes write, or that a later read returns.

The bus lines are sampled with a fast system clock. SDA is modelled as a sampled level plus a pull-low enable. Each pin likewise has a sampled input, an output value and an output enable. An open-drain interrupt, modelled as a pull-low enable, tells the host that an input pin has moved away from the value it last read. The host then reads the pin register, which clears the interrupt. An active-low reset returns every register to its default and holds the bus logic idle for as long as it is low.

Top module: `i2c_pin_expander`

## Requirements
- R1: The slave answers the 7-bit address made of 11100 followed by strap bit 1 and then strap bit 0 (R/W is bit 0 of the address byte: 0 writes, 1 reads). It acknowledges that address and no other, and it never pulls SDA low for a foreign address.
- R2: A write is the address with R/W=0, a command byte, then data bytes. Each acknowledged data byte is stored in the register the command selected. Further data bytes in the same transfer overwrite that same register.
- R3: Command codes are 00h pin levels, 01h output values, 02h inversion mask and 03h direction. A command above 03h is not acknowledged and leaves the register pointer and all registers unchanged.
- R4: A read returns the pointed register, starting at the byte after the address with R/W=1 (usually behind a repeated START that follows a command). Each byte the host acknowledges is followed by the same register again. A host NACK ends the transfer.
- R5: Register 00h returns the sampled pins XOR the inversion mask, whatever the pin directions. Data written to 00h is acknowledged but changes nothing.
- R6: A direction bit of 1 makes the pin an input (output enable low). A direction bit of 0 enables the pin's output, driving the matching bit of the output-value register.
- R7: After reset the direction register is FFh, the output register is FFh and the inversion mask is 00h. No pin is driven, SDA is released and the interrupt is inactive.
- R8: The interrupt is pulled low within 4 clocks of an input-direction pin's inverted level differing from the captured pin register. A pin configured as an output never raises it.
- R9: The pin register is recaptured each time a byte of register 00h is loaded for a read (after the address acknowledge and after each host acknowledge). The capture clears the interrupt when the pins are steady.
- R10: While the reset input is low, every register holds its default and any transfer in progress is abandoned. After release the slave waits for a new START.
- R11: The slave changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 2 | Low two bits of the slave address |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull | output | 1 | 1 pulls SDA low |
| pin_i | input | 8 | Levels seen on the pins |
| pin_oe | output | 8 | Per-pin output enable |
| pin_o | output | 8 | Per-pin output value |
| irq_pull | output | 1 | 1 pulls the interrupt line low |

## Verification
On every cycle the embedded properties check several things. SDA never moves while SCL is high, and a skipped transfer never drives the bus. Writes aimed at the pin register leave the writable registers untouched. A read load of register 00h captures the inverted pin levels, and an all-output configuration cannot raise the interrupt. The scenarios alone can show the rest. These are the complete bus exchanges: address matching against the straps, NACK of bad commands with the pointer kept, repeated reads of one register, and the reset default values. They also cover the end-to-end path from a pin edge to the interrupt and its clearing by a read of the pin register.

// File: rtl/pex_pkg.sv
package pex_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_PINS = 2'd0;
  localparam logic [SEL_W-1:0] SEL_OUT  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_INV  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_DIR  = 2'd3;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_CMD,
    LK_WDATA,
    LK_RDATA,
    LK_SKIP
  } link_state_t;
endpackage

// File: rtl/pex_sync.sv
module pex_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pex_link.sv
module pex_link
  import pex_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [SEL_W-1:0]  ptr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              ld_stb,
  output logic              sda_pull
);
  link_state_t       st_q, st_d, nxt_q, nxt_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic [SEL_W-1:0]  ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic              scl_p, sda_p;
  logic              rise, fall, start, stop;
  logic [BYTE_W-1:0] byte_in;

  assign rise    = scl_s & ~scl_p;
  assign fall    = ~scl_s & scl_p;
  assign start   = scl_s & scl_p & sda_p & ~sda_s;
  assign stop    = scl_s & scl_p & ~sda_p & sda_s;
  assign byte_in = {rx_q[BYTE_W-2:0], sda_s};

  always_comb begin
    st_d   = st_q;
    nxt_d  = nxt_q;
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    ptr_d  = ptr_q;
    oe_d   = oe_q;
    wr_stb = 1'b0;
    ld_stb = 1'b0;
    if (stop) begin
      st_d = LK_IDLE;
      oe_d = 1'b0;
    end else if (start) begin
      st_d  = LK_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        LK_ADDR, LK_CMD, LK_WDATA: begin
          if (rise && cnt_q < 4'd8) begin
            rx_d  = byte_in;
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              if (st_q == LK_ADDR) begin
                if (byte_in[7:1] == {ADDR_HI, strap}) nxt_d = byte_in[0] ? LK_RDATA : LK_CMD;
                else st_d = LK_SKIP;
              end else if (st_q == LK_CMD) begin
                if (byte_in < 8'd4) begin
                  ptr_d = byte_in[SEL_W-1:0];
                  nxt_d = LK_WDATA;
                end else st_d = LK_SKIP;
              end else begin
                wr_stb = 1'b1;
                nxt_d  = LK_WDATA;
              end
            end
          end else if (fall && cnt_q == 4'd8) begin
            oe_d  = 1'b1;
            cnt_d = 4'd9;
          end else if (fall && cnt_q == 4'd9) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = nxt_q;
            if (nxt_q == LK_RDATA) begin
              ld_stb = 1'b1;
              tx_d   = rd_byte;
              oe_d   = ~rd_byte[BYTE_W-1];
            end
          end
        end
        LK_RDATA: begin
          if (rise && cnt_q < 4'd8) cnt_d = cnt_q + 4'd1;
          else if (rise && cnt_q == 4'd8) begin
            if (sda_s) st_d = LK_SKIP;
            else cnt_d = 4'd9;
          end else if (fall && cnt_q != 4'd0 && cnt_q < 4'd8) begin
            tx_d = {tx_q[BYTE_W-2:0], 1'b0};
            oe_d = ~tx_q[BYTE_W-2];
          end else if (fall && cnt_q == 4'd8) oe_d = 1'b0;
          else if (fall && cnt_q == 4'd9) begin
            ld_stb = 1'b1;
            tx_d   = rd_byte;
            oe_d   = ~rd_byte[BYTE_W-1];
            cnt_d  = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LK_IDLE;
      nxt_q <= LK_IDLE;
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
      ptr_q <= SEL_PINS;
      oe_q  <= 1'b0;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      st_q  <= st_d;
      nxt_q <= nxt_d;
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      ptr_q <= ptr_d;
      oe_q  <= oe_d;
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign ptr      = ptr_q;
  assign wr_byte  = byte_in;
  assign sda_pull = oe_q;

  AST_SKIP_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == LK_SKIP |-> !oe_q); // R1
  AST_SDA_HELD_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_p && !start && !stop) |=> $stable(oe_q)); // R11
endmodule

// File: rtl/pex_regs.sv
module pex_regs
  import pex_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pins_s,
  input  logic [SEL_W-1:0]  ptr,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              ld_stb,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] pin_oe,
  output logic [BYTE_W-1:0] pin_o,
  output logic              irq
);
  logic [BYTE_W-1:0] in_q, in_d, out_q, out_d, inv_q, inv_d, dir_q, dir_d;
  logic [BYTE_W-1:0] pin_adj;
  logic [1:0]        prime_q, prime_d;
  logic              primed, irq_q, irq_d;

  assign primed  = (prime_q == 2'd3);
  assign pin_adj = pins_s ^ inv_q;

  always_comb begin
    out_d   = out_q;
    inv_d   = inv_q;
    dir_d   = dir_q;
    prime_d = primed ? prime_q : prime_q + 2'd1;
    in_d    = (!primed || (ld_stb && ptr == SEL_PINS)) ? pin_adj : in_q;
    if (wr_stb) begin
      unique case (ptr)
        SEL_OUT: out_d = wr_byte;
        SEL_INV: inv_d = wr_byte;
        SEL_DIR: dir_d = wr_byte;
        default: ;
      endcase
    end
    irq_d = primed && |((pin_adj ^ in_d) & dir_d);
    unique case (ptr)
      SEL_PINS: rd_byte = pin_adj;
      SEL_OUT:  rd_byte = out_q;
      SEL_INV:  rd_byte = inv_q;
      default:  rd_byte = dir_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '1;
      out_q   <= '1;
      inv_q   <= '0;
      dir_q   <= '1;
      prime_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      in_q    <= in_d;
      out_q   <= out_d;
      inv_q   <= inv_d;
      dir_q   <= dir_d;
      prime_q <= prime_d;
      irq_q   <= irq_d;
    end
  end

  assign pin_oe = ~dir_q;
  assign pin_o  = out_q;
  assign irq    = irq_q;

  AST_PIN_REG_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ptr == SEL_PINS) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q))); // R5
  AST_CAPTURE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && ld_stb && ptr == SEL_PINS) |=> in_q == $past(pin_adj)); // R9
  AST_OUTPUTS_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == '0 && !wr_stb) |=> !irq_q); // R8
endmodule

// File: rtl/i2c_pin_expander.sv
module i2c_pin_expander
  import pex_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b11100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr_strap,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull,
  input  logic [7:0]  pin_i,
  output logic [7:0]  pin_oe,
  output logic [7:0]  pin_o,
  output logic        irq_pull
);
  localparam int SW = BYTE_W + 2;

  logic [SW-1:0]     synced;
  logic [SEL_W-1:0]  ptr;
  logic              wr_stb, ld_stb;
  logic [BYTE_W-1:0] wr_byte, rd_byte;

  pex_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i, pin_i}), .q_o(synced)
  );

  pex_link #(.ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(rst_n),
    .scl_s(synced[SW-1]), .sda_s(synced[SW-2]), .strap(addr_strap),
    .rd_byte(rd_byte), .ptr(ptr), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .ld_stb(ld_stb), .sda_pull(sda_pull)
  );

  pex_regs u_regs (
    .clk(clk), .rst_n(rst_n), .pins_s(synced[BYTE_W-1:0]), .ptr(ptr),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .ld_stb(ld_stb), .rd_byte(rd_byte),
    .pin_oe(pin_oe), .pin_o(pin_o), .irq(irq_pull)
  );
endmodule

// File: tb/i2c_pin_expander_bench.sv
module i2c_pin_expander_bench;
  localparam int Q     = 20;
  localparam int LIMIT = 150000;
  localparam logic [7:0] AW = 8'hE2;
  localparam logic [7:0] AR = 8'hE3;
  localparam logic [23:0] VECS [0:5] = '{24'h015A5A, 24'h020F0F, 24'h03F0F0,
                                         24'h030000, 24'h01A5A5, 24'h020000};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_rel = 1'b1;
  logic [7:0] pins = 8'h00;
  logic sda_pull, irq_pull, sda_bus;
  logic [7:0] pin_oe, pin_o;
  int n_chk = 0, n_bad = 0, cyc = 0, viol = 0;
  logic scl_prev = 1'b1, pull_prev = 1'b0;

  assign sda_bus = m_rel & ~sda_pull;
  always #5 clk = ~clk;

  i2c_pin_expander u_i2c_pin_expander (
    .clk(clk), .rst_n(rst_n), .addr_strap(2'b01), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull(sda_pull), .pin_i(pins), .pin_oe(pin_oe), .pin_o(pin_o), .irq_pull(irq_pull)
  );

  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && sda_pull != pull_prev) viol++; // R11 monitor
    scl_prev  <= scl;
    pull_prev <= sda_pull;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half(); repeat (Q) @(negedge clk); endtask
  task automatic i_start(); m_rel = 1; scl = 1; half(); m_rel = 0; half(); scl = 0; half(); endtask
  task automatic i_rstart(); m_rel = 1; half(); scl = 1; half(); m_rel = 0; half(); scl = 0; half(); endtask
  task automatic i_stop(); m_rel = 0; half(); scl = 1; half(); m_rel = 1; half(); half(); endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_rel = b[i]; half(); scl = 1; half(); scl = 0;
    end
    m_rel = 1; half(); scl = 1; half(); ack = ~sda_bus; scl = 0; half();
  endtask

  task automatic recv(input logic ack, output logic [7:0] b);
    m_rel = 1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl = 1; half(); b[i] = sda_bus; scl = 0;
    end
    m_rel = ~ack; half(); scl = 1; half(); scl = 0; m_rel = 1;
  endtask

  task automatic wr(input logic [7:0] cmd, input logic [7:0] d, output logic [2:0] acks);
    i_start(); send(AW, acks[2]); send(cmd, acks[1]); send(d, acks[0]); i_stop();
  endtask

  task automatic rd(input logic [7:0] cmd, output logic [7:0] d);
    logic a;
    i_start(); send(AW, a); send(cmd, a); i_rstart(); send(AR, a); recv(1'b0, d); i_stop();
  endtask

  initial begin
    logic [2:0] acks;
    logic [7:0] d, d2;
    logic a;
    repeat (10) @(negedge clk);
    chk("R7 pin_oe in reset", pin_oe, 8'h00);
    chk("R7 irq in reset", {7'd0, irq_pull}, 8'h00);
    chk("R7 sda released", {7'd0, sda_pull}, 8'h00);
    rst_n = 1; half();
    rd(8'h03, d); chk("R7 direction default", d, 8'hFF);
    rd(8'h01, d); chk("R7 output default", d, 8'hFF);
    rd(8'h02, d); chk("R7 inversion default", d, 8'h00);

    for (int v = 0; v < 6; v++) begin // R2 vector walk
      wr(VECS[v][23:16], VECS[v][15:8], acks);
      chk("R2 write acks", {5'd0, acks}, 8'h07);
      rd(VECS[v][23:16], d);
      chk("R2 readback", d, VECS[v][7:0]);
    end

    i_start(); send(AW, a); send(8'h01, a); send(8'h11, a); send(8'h22, a); i_stop();
    rd(8'h01, d); chk("R2 last byte of burst kept", d, 8'h22);

    wr(8'h03, 8'h0F, acks); wr(8'h01, 8'hA5, acks);
    chk("R6 output enables", pin_oe, 8'hF0);
    chk("R6 output values", pin_o, 8'hA5);

    i_start(); send(8'hE0, a); chk("R1 foreign address nack", {7'd0, a}, 8'h00);
    chk("R1 sda not driven", {7'd0, sda_pull}, 8'h00); i_stop();

    i_start(); send(AW, a); send(8'h07, a); i_stop();
    chk("R3 bad command nack", {7'd0, a}, 8'h00);
    i_start(); send(AR, a); recv(1'b0, d); i_stop();
    chk("R3 pointer kept", d, 8'hA5);
    rd(8'h03, d); chk("R3 direction untouched", d, 8'h0F);

    wr(8'h03, 8'hFF, acks); wr(8'h02, 8'h0F, acks);
    pins = 8'h3C; half();
    rd(8'h00, d); chk("R5 inverted pins", d, 8'h33);
    wr(8'h00, 8'h00, acks); chk("R5 write to pins acked", {5'd0, acks}, 8'h07);
    rd(8'h00, d); chk("R5 pin register unchanged", d, 8'h33);
    rd(8'h03, d); chk("R5 direction unchanged", d, 8'hFF);

    i_start(); send(AW, a); send(8'h02, a); i_rstart(); send(AR, a);
    recv(1'b1, d); recv(1'b0, d2); i_stop();
    chk("R4 first byte", d, 8'h0F);
    chk("R4 repeated byte", d2, 8'h0F);

    wr(8'h02, 8'h00, acks);
    rd(8'h00, d); chk("R9 capture", d, 8'h3C);
    chk("R9 irq idle after capture", {7'd0, irq_pull}, 8'h00);
    pins = 8'h3D; repeat (6) @(negedge clk);
    chk("R8 irq on input change", {7'd0, irq_pull}, 8'h01);
    rd(8'h00, d); chk("R9 recapture", d, 8'h3D);
    chk("R9 irq cleared by read", {7'd0, irq_pull}, 8'h00);
    wr(8'h03, 8'hFE, acks);
    pins = 8'h3C; repeat (6) @(negedge clk);
    chk("R8 output pin no irq", {7'd0, irq_pull}, 8'h00);

    wr(8'h03, 8'h00, acks);
    chk("R10 all outputs before reset", pin_oe, 8'hFF);
    i_start(); send(AW, a);
    rst_n = 0; repeat (5) @(negedge clk);
    chk("R10 pins released in reset", pin_oe, 8'h00);
    chk("R10 sda released in reset", {7'd0, sda_pull}, 8'h00);
    scl = 1; m_rel = 1; half(); rst_n = 1; half();
    chk("R10 no irq after release", {7'd0, irq_pull}, 8'h00);
    rd(8'h03, d); chk("R10 direction default after reset", d, 8'hFF);

    chk("R11 sda changes while scl high", viol[7:0], 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule